// File: doc/BRIEF.md
# Character Cell Pixel Shifter with Fine Scroll

This block turns one font byte per character cell into a serial pixel stream on the dot clock. A dot down-counter divides the scan line into cells of a programmable width of 2 to 8 dots. Once per cell, at a programmable scroll phase, it raises a fetch request and captures the font byte that is presented on that dot. The byte then shifts out most-significant bit first, one bit per dot.

A second per-cell down-counter sets how many dots into the cell the shifter is cleared. This lets a cell show fewer pixels than it is wide. When the scroll phase is late, the captured byte spills across the cell boundary into the next cell. That is how fine horizontal scrolling moves the image by single pixels.

Memory fetching and attribute colouring are done by neighbouring blocks. The horizontal display-enable input blanks the output outside the playfield.

Top module: `chr_pixel_shifter`

## Requirements
- R1: After reset the pixel output and the fetch request are 0 and the cell-end strobe is 1 in the first dot, because the dot counter resets to zero. The shifter also starts empty, so the pixel output stays 0 until the first byte is loaded.
- R2: With the width field at w, each cell lasts w+1 dots. Values below 1 are treated as 1 and values above 7 as 7, so a cell is 2 to 8 dots. The cell-end strobe is high on the last dot of each cell and low on every other dot.
- R3: The fetch request is high for exactly one dot per cell: dot s of the cell, where s is the scroll field and dots are counted from 0 at the cell's first dot. If s is larger than w, no request is made in that cell. On the clock edge ending that dot, the font byte is captured.
- R4: A captured byte appears on the pixel output from the next dot onward, bit 7 first, then bit 6 and so on. Zeros fill in behind the last bit.
- R5: With the shown field at d and d no larger than w, the shifter is cleared at the end of dot d of each cell, which blanks the rest of the cell. If the fetch request falls on the same dot, the new byte is kept instead.
- R6: While the display-enable input is low, the pixel output is 0. The shifter keeps running underneath, so the bits it holds reappear unchanged when display enable returns.
- R7: A late scroll phase carries a byte across the cell boundary. For example, w=7, s=4 and d=1 show five pixels per byte: three at the end of the cell and two at the start of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hde_i | input | 1 | Horizontal display enable |
| font_i | input | FONT_W | Font byte for the current fetch |
| cell_cfg_i | input | CNT_W | Cell width minus one (w) |
| shown_cfg_i | input | CNT_W | Dot index at which the cell is blanked (d) |
| scroll_i | input | CNT_W | Dot index at which the font byte is loaded (s) |
| pix_o | output | 1 | Serial pixel |
| fetch_o | output | 1 | Load pulse requesting the next fetch |
| cell_end_o | output | 1 | High on the last dot of each cell |

## Verification
The 8-dot cell is swept over every pairing of scroll phase and blanking dot, 0 to 15 each. This separates loads inside the cell from loads that spill into the next cell, and blanking before a load from blanking after one, including the case where both fall on the same dot. A second sweep steps the width field from 0 to 15 with early, middle and last-dot scroll phases. It tells the clamped widths apart from the legal ones and shows the cell-end strobe period. The font byte changes on every dot and display enable drops in periodic bursts. Together these show whether the byte was sampled on the right edge, whether it shifts out in the right order, and whether blanking hides pixels without disturbing the shifter.

// File: rtl/chr_shift_pkg.sv
package chr_shift_pkg;

   // Action applied to the shift register on the next dot
   typedef enum logic [1:0] {
      SH_SHIFT = 2'd0,
      SH_LOAD  = 2'd1,
      SH_CLEAR = 2'd2
   } sh_action_e;

endpackage

// File: rtl/chr_cell_timer.sv
module chr_cell_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] width_m1,
   output logic             last_dot
);
   logic [CNT_W-1:0] dot_q;

   assign last_dot = (dot_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)        dot_q <= '0;
      else if (last_dot) dot_q <= width_m1;
      else               dot_q <= dot_q - 1'b1;
   end
endmodule

// File: rtl/chr_phase_counter.sv
module chr_phase_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] preset,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   // Fires once when the armed count reaches zero
   assign hit = armed_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (restart) begin
         cnt_q   <= preset;
         armed_q <= 1'b1;
      end else begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         if (hit)         armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/chr_font_shifter.sv
module chr_font_shifter
   import chr_shift_pkg::*;
#(
   parameter int FONT_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sh_action_e        action,
   input  logic [FONT_W-1:0] font,
   output logic              pix_raw
);
   logic [FONT_W-1:0] sr_q;
   logic [FONT_W-1:0] sr_shifted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sr_shifted = {sr_q[FONT_W-2:0], 1'b0};
         assign pix_raw    = sr_q[FONT_W-1];
      end else begin : g_lsb
         assign sr_shifted = {1'b0, sr_q[FONT_W-1:1]};
         assign pix_raw    = sr_q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else begin
         case (action)
            SH_LOAD:  sr_q <= font;
            SH_CLEAR: sr_q <= '0;
            default:  sr_q <= sr_shifted;
         endcase
      end
   end
endmodule

// File: rtl/chr_pixel_shifter.sv
module chr_pixel_shifter
   import chr_shift_pkg::*;
#(
   parameter int FONT_W    = 8,
   parameter int CNT_W     = 4,
   parameter int MAX_CELL  = 8,
   parameter int MIN_CELL  = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hde_i,
   input  logic [FONT_W-1:0] font_i,
   input  logic [CNT_W-1:0]  cell_cfg_i,
   input  logic [CNT_W-1:0]  shown_cfg_i,
   input  logic [CNT_W-1:0]  scroll_i,
   output logic              pix_o,
   output logic              fetch_o,
   output logic              cell_end_o
);
   localparam logic [CNT_W-1:0] W_HI = CNT_W'(MAX_CELL - 1);
   localparam logic [CNT_W-1:0] W_LO = CNT_W'(MIN_CELL - 1);

   generate
      if (MIN_CELL < 2 || MAX_CELL < MIN_CELL || MAX_CELL > FONT_W) begin : g_bad_cell
         $error("chr_pixel_shifter: cell size limits out of range");
      end
      if ((1 << CNT_W) < MAX_CELL) begin : g_bad_cnt
         $error("chr_pixel_shifter: CNT_W too narrow for MAX_CELL");
      end
   endgenerate

   logic [CNT_W-1:0] width_m1;
   logic             last_dot;
   logic             blank_hit;
   logic             pix_raw;
   sh_action_e       action;

   always_comb begin
      width_m1 = cell_cfg_i;
      if (cell_cfg_i > W_HI)      width_m1 = W_HI;
      else if (cell_cfg_i < W_LO) width_m1 = W_LO;
   end

   chr_cell_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .width_m1 (width_m1),
      .last_dot (last_dot)
   );

   chr_phase_counter #(.CNT_W(CNT_W)) u_scroll (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (last_dot),
      .preset  (scroll_i),
      .hit     (fetch_o)
   );

   chr_phase_counter #(.CNT_W(CNT_W)) u_shown (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (last_dot),
      .preset  (shown_cfg_i),
      .hit     (blank_hit)
   );

   // A load on the same dot as the blanking point wins
   always_comb begin
      if (fetch_o)        action = SH_LOAD;
      else if (blank_hit) action = SH_CLEAR;
      else                action = SH_SHIFT;
   end

   chr_font_shifter #(.FONT_W(FONT_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .action  (action),
      .font    (font_i),
      .pix_raw (pix_raw)
   );

   assign pix_o      = pix_raw & hde_i;
   assign cell_end_o = last_dot;
endmodule

// File: rtl/chr_pixel_shifter_chk.sv
module chr_pixel_shifter_chk (
   input logic clk,
   input logic rst_n,
   input logic hde_i,
   input logic font_msb,
   input logic pix_o,
   input logic fetch_o,
   input logic cell_end_o
);
   // R6
   blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hde_i |-> !pix_o);

   // R3
   single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> !fetch_o);

   // R2
   cell_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_end_o |=> !cell_end_o);

   // R4
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |=> (!hde_i || (pix_o == $past(font_msb))));
endmodule

bind chr_pixel_shifter chr_pixel_shifter_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .hde_i      (hde_i),
   .font_msb   (font_i[FONT_W-1]),
   .pix_o      (pix_o),
   .fetch_o    (fetch_o),
   .cell_end_o (cell_end_o)
);

// File: tb/chr_pixel_shifter_tb_top.sv
module chr_pixel_shifter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hde_i = 1'b0;
   logic [7:0] font_i = '0;
   logic [3:0] cell_cfg_i = 4'd7;
   logic [3:0] shown_cfg_i = 4'd8;
   logic [3:0] scroll_i = 4'd0;
   logic       pix_o, fetch_o, cell_end_o;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   chr_pixel_shifter dut_i (
      .clk(clk), .rst_n(rst_n), .hde_i(hde_i), .font_i(font_i),
      .cell_cfg_i(cell_cfg_i), .shown_cfg_i(shown_cfg_i), .scroll_i(scroll_i),
      .pix_o(pix_o), .fetch_o(fetch_o), .cell_end_o(cell_end_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Reference: reset, then compare every dot against a behavioural model
   task automatic run_cfg(input int w, input int s, input int d, input int ncyc);
      int weff, pos, msr;
      bit exp_load, exp_clr, exp_end, exp_pix;
      string preq;
      weff = (w > 7) ? 7 : ((w < 1) ? 1 : w);
      cell_cfg_i = 4'(w); scroll_i = 4'(s); shown_cfg_i = 4'(d);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      msr = 0;
      for (int n = 0; n < ncyc; n++) begin
         font_i = 8'((n * 73 + 29 + s * 5 + d) & 255);
         hde_i  = ((n % 19) >= 3);
         #1;
         pos      = (n == 0) ? -1 : (n - 1) % (weff + 1);
         exp_end  = (n == 0) || (pos == weff);
         exp_load = (n > 0) && (pos == s);
         exp_clr  = (n > 0) && (pos == d);
         exp_pix  = hde_i ? msr[7] : 1'b0;
         // R1 reset state at first dot; R2 strobe period and clamp
         check((n == 0) ? "R1" : "R2", cell_end_o, exp_end);
         // R3 fetch dot
         check((n == 0) ? "R1" : "R3", fetch_o, exp_load);
         // R4 MSB-first, R5 blanking, R6 display enable, R7 carry across cells
         if (n == 0) preq = "R1";
         else if (!hde_i) preq = "R6";
         else if (w == 7 && s == 4 && d == 1) preq = "R7";
         else if (d <= weff) preq = "R5";
         else preq = "R4";
         check(preq, pix_o, exp_pix);
         if (exp_load) msr = font_i;
         else if (exp_clr) msr = 0;
         else msr = (msr << 1) & 255;
         @(negedge clk);
      end
   endtask

   initial begin
      // R7 documented 5-of-8 scroll case first
      run_cfg(7, 4, 1, 80);
      // R3 R5 full sweep of scroll phase and blanking dot on 8-dot cells
      for (int s = 0; s < 16; s++)
         for (int d = 0; d < 16; d++)
            run_cfg(7, s, d, 40);
      // R2 width sweep including clamped values
      for (int w = 0; w < 16; w++)
         for (int k = 0; k < 3; k++) begin
            int s2, d2;
            s2 = (k == 0) ? 0 : ((k == 1) ? w / 2 : w);
            d2 = (k == 0) ? 15 : ((k == 1) ? w : 0);
            run_cfg(w, s2, d2, 40);
         end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule